// File: doc/BRIEF.md
# Write-Driven Interrupt Line Bank

This block holds a bank of level-sensitive interrupt request lines. Software controls them through a short window of I/O-port addresses, with one byte-wide location for each line. A one-byte write to a location sets the matching line from the written byte. Any nonzero byte raises the line and a zero byte lowers it. The line then keeps that level until its own location is written again.

The window starts at a base port address, 0x2000 by default, and covers one address per line, 24 by default. Reads inside or outside the window are accepted and return zero. Reads never change a line. Accesses of any width other than one byte are dropped, and so are addresses outside the window. The line levels leave the block as a registered vector. Bit n of that vector is the line at base + n. The vector feeds an interrupt controller elsewhere on the chip.

Top module: `irq_level_bank`

## Requirements
- R1: While `rst` is high, all bits of `irq_out` are zero from the first clock edge that samples it; a reset in mid-run clears every line.
- R2: A write with `io_size` = 1 to address BASE + n (0 ≤ n < 24) and a nonzero low byte `io_wdata[7:0]` sets `irq_out[n]` high at the clock edge that samples the write.
- R3: The same write with `io_wdata[7:0]` = 0 sets `irq_out[n]` low at that edge.
- R4: Only `io_wdata[7:0]` decides the new level. Bits 31:8 are ignored, so 0x00000100 lowers the line and 0xFFFFFF10 raises it.
- R5: A write changes at most the one addressed line. With no accepted write, every line keeps its level.
- R6: A write whose `io_size` is not 1 (byte counts 0, 2 or 4 are tried) leaves every line unchanged.
- R7: A write to an address below BASE, or at BASE + 24 or above (including addresses that differ from the window only in high bits), leaves every line unchanged.
- R8: `io_rdata` is zero on every cycle, including during a read of any address. A read never changes any line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| io_addr | input | 16 | I/O-port address |
| io_size | input | 3 | Access width in bytes (1 is the only accepted value) |
| io_wdata | input | 32 | Write data; only bits 7:0 are used |
| io_wr | input | 1 | Write strobe, one cycle per access |
| io_rd | input | 1 | Read strobe |
| io_rdata | output | 32 | Read data, always zero |
| irq_out | output | 24 | Registered interrupt line levels, bit n for address BASE + n |

## Verification
The main function is tried with writes of one-bit, all-ones and multi-bit low bytes to the first line, the last line and lines in between. The same lines are then written with zero. This shows that the nonzero test applies to the whole byte and not to one bit of it. Data words whose only set bits lie above bit 7, and words that combine high bits with a nonzero low byte, show that the upper bits have no effect. Writes one address below the window, one address past it, at an aliased high address, and with widths 0, 2 and 4, are all checked against the unchanged vector. Checking the whole vector after every write shows that each write touches only its own line.

// File: rtl/irq_bank_pkg.sv
package irq_bank_pkg;

  // Access width code for the one accepted size (a count of bytes).
  localparam logic [2:0] SIZE_ONE_BYTE = 3'd1;

  // Width of the data field that decides a line level.
  localparam int unsigned LEVEL_BYTE_BITS = 8;

endpackage

// File: rtl/irq_window_decode.sv
module irq_window_decode #(
  parameter int unsigned ADDR_W    = 16,
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned SIZE_W    = 3,
  parameter int unsigned NUM_LINES = 24,
  parameter int unsigned BASE_ADDR = 32'h2000
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [ADDR_W-1:0]    addr,
  input  logic [SIZE_W-1:0]    size,
  input  logic [DATA_W-1:0]    wdata,
  input  logic                 wr,
  output logic [NUM_LINES-1:0] line_we,
  output logic                 line_lvl
);
  import irq_bank_pkg::*;

  localparam logic [DATA_W-1:0] LEVEL_MASK = DATA_W'((64'd1 << LEVEL_BYTE_BITS) - 64'd1);

  logic [NUM_LINES-1:0] addr_hit;
  logic                 size_ok;

  assign size_ok  = (size == SIZE_W'(SIZE_ONE_BYTE));
  assign line_lvl = |(wdata & LEVEL_MASK);

  for (genvar i = 0; i < NUM_LINES; i++) begin : g_hit
    assign addr_hit[i] = (addr == ADDR_W'(BASE_ADDR + i));
    assign line_we[i]  = wr & size_ok & addr_hit[i];
  end

  // R5: one write enable at most per cycle
  a_r5_one_line: assert property (@(posedge clk) disable iff (rst) $onehot0(line_we));
  // R6: no enable for a wrong-width access
  a_r6_size_gate: assert property (@(posedge clk) disable iff (rst)
    (size != SIZE_W'(SIZE_ONE_BYTE)) |-> (line_we == '0));

endmodule

// File: rtl/irq_line_reg.sv
module irq_line_reg (
  input  logic clk,
  input  logic rst,
  input  logic we,
  input  logic lvl,
  output logic q
);

  always_ff @(posedge clk) begin
    if (rst)     q <= 1'b0;
    else if (we) q <= lvl;
  end

  // R2: an accepted nonzero write raises the line
  a_r2_raise: assert property (@(posedge clk) disable iff (rst) (we && lvl) |=> q);
  // R3: an accepted zero write lowers the line
  a_r3_lower: assert property (@(posedge clk) disable iff (rst) (we && !lvl) |=> !q);
  // R5: the line keeps its level without its own write
  a_r5_hold: assert property (@(posedge clk) disable iff (rst) !we |=> $stable(q));

endmodule

// File: rtl/irq_level_bank.sv
module irq_level_bank #(
  parameter int unsigned ADDR_W    = 16,
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned SIZE_W    = 3,
  parameter int unsigned NUM_LINES = 24,
  parameter int unsigned BASE_ADDR = 32'h2000
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [ADDR_W-1:0]    io_addr,
  input  logic [SIZE_W-1:0]    io_size,
  input  logic [DATA_W-1:0]    io_wdata,
  input  logic                 io_wr,
  input  logic                 io_rd,
  output logic [DATA_W-1:0]    io_rdata,
  output logic [NUM_LINES-1:0] irq_out
);
  import irq_bank_pkg::*;

  localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(BASE_ADDR + NUM_LINES - 1);

  logic [NUM_LINES-1:0] line_we;
  logic                 line_lvl;

  irq_window_decode #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SIZE_W(SIZE_W),
    .NUM_LINES(NUM_LINES), .BASE_ADDR(BASE_ADDR)
  ) u_dec (
    .clk(clk), .rst(rst), .addr(io_addr), .size(io_size), .wdata(io_wdata),
    .wr(io_wr), .line_we(line_we), .line_lvl(line_lvl)
  );

  for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
    irq_line_reg u_line (
      .clk(clk), .rst(rst), .we(line_we[i]), .lvl(line_lvl), .q(irq_out[i])
    );
  end

  // Reads are accepted and answer zero whatever the address.
  assign io_rdata = {DATA_W{1'b0}} & {DATA_W{io_rd}};

  // R1: lines are low after a reset cycle
  a_r1_reset_low: assert property (@(posedge clk) rst |=> (irq_out == '0));
  // R5: a write changes at most one line
  a_r5_single_change: assert property (@(posedge clk) disable iff (rst)
    io_wr |=> ($countones(irq_out ^ $past(irq_out)) <= 1));
  // R6: wrong-width writes change nothing
  a_r6_size_ignored: assert property (@(posedge clk) disable iff (rst)
    (io_wr && io_size != SIZE_W'(SIZE_ONE_BYTE)) |=> $stable(irq_out));
  // R7: out-of-window writes change nothing
  a_r7_window: assert property (@(posedge clk) disable iff (rst)
    (io_wr && (io_addr < ADDR_W'(BASE_ADDR) || io_addr > LAST_ADDR)) |=> $stable(irq_out));
  // R8: reads without a write change nothing
  a_r8_read_quiet: assert property (@(posedge clk) disable iff (rst)
    (io_rd && !io_wr) |=> $stable(irq_out));

endmodule

// File: tb/irq_level_bank_test.sv
module irq_level_bank_test;

  typedef struct packed {
    logic [15:0] addr;
    logic [2:0]  size;
    logic [31:0] data;
    logic [23:0] expv;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VECS [NV] = '{
    '{16'h2000, 3'd1, 32'h0000_0001, 24'h000001, 8'd2}, // R2 first line
    '{16'h2017, 3'd1, 32'h0000_0080, 24'h800001, 8'd2}, // R2 last line
    '{16'h2005, 3'd1, 32'h0000_00FF, 24'h800021, 8'd2}, // R2 all ones
    '{16'h2005, 3'd1, 32'h0000_0000, 24'h800001, 8'd3}, // R3 lower
    '{16'h2003, 3'd1, 32'h0000_0100, 24'h800001, 8'd4}, // R4 high bit only
    '{16'h2003, 3'd1, 32'hFFFF_FF10, 24'h800009, 8'd4}, // R4 mixed
    '{16'h2000, 3'd2, 32'h0000_0000, 24'h800009, 8'd6}, // R6 two bytes
    '{16'h2000, 3'd4, 32'h0000_0000, 24'h800009, 8'd6}, // R6 four bytes
    '{16'h2018, 3'd1, 32'h0000_00FF, 24'h800009, 8'd7}, // R7 past end
    '{16'h1FFF, 3'd1, 32'h0000_00FF, 24'h800009, 8'd7}, // R7 below base
    '{16'h2017, 3'd1, 32'h0000_0000, 24'h000009, 8'd3}, // R3 last line
    '{16'h200C, 3'd1, 32'h0000_0003, 24'h001009, 8'd2}, // R2 middle line
    '{16'h2000, 3'd0, 32'h0000_0000, 24'h001009, 8'd6}, // R6 zero width
    '{16'hA000, 3'd1, 32'h0000_00FF, 24'h001009, 8'd7}  // R7 aliased high bits
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] io_addr = '0;
  logic [2:0]  io_size = '0;
  logic [31:0] io_wdata = '0;
  logic        io_wr = 1'b0;
  logic        io_rd = 1'b0;
  logic [31:0] io_rdata;
  logic [23:0] irq_out;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  irq_level_bank uut (
    .clk(clk), .rst(rst), .io_addr(io_addr), .io_size(io_size),
    .io_wdata(io_wdata), .io_wr(io_wr), .io_rd(io_rd),
    .io_rdata(io_rdata), .irq_out(irq_out)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr_access(input logic [15:0] a, input logic [2:0] s, input logic [31:0] d);
    @(negedge clk);
    io_addr = a; io_size = s; io_wdata = d; io_wr = 1'b1;
    @(negedge clk);
    io_wr = 1'b0;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin : main
    logic [23:0] held;
    repeat (3) @(negedge clk);
    check("R1 reset low", 32'(irq_out), 32'h0);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      wr_access(VECS[i].addr, VECS[i].size, VECS[i].data);
      check($sformatf("R%0d vector %0d", VECS[i].req, i), 32'(irq_out), 32'(VECS[i].expv));
    end

    // R5: idle cycles keep all levels
    held = irq_out;
    repeat (5) @(negedge clk);
    check("R5 hold idle", 32'(irq_out), 32'(held));

    // R8: reads answer zero and leave lines alone
    for (int a = 16'h1FFF; a <= 16'h2018; a += 5) begin
      @(negedge clk);
      io_addr = 16'(a); io_size = 3'd1; io_rd = 1'b1;
      #1;
      check("R8 read data", io_rdata, 32'h0);
      @(negedge clk);
      io_rd = 1'b0;
      check("R8 read no effect", 32'(irq_out), 32'(held));
    end

    // R2/R5: raise every line one by one
    for (int n = 0; n < 24; n++) wr_access(16'(16'h2000 + n), 3'd1, 32'h40);
    check("R2 all lines high", 32'(irq_out), 32'hFFFFFF);

    // R1: mid-run reset clears everything
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    check("R1 mid-run reset", 32'(irq_out), 32'h0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule